// File: doc/BRIEF.md
# Keyed 32-bit Word Scrambler

This block is a keyed, reversible scrambler for 32-bit words. A 64-bit key selects one bijection out of a large family. The intended use is index hashing: a lookup structure scrambles a 32-bit address before it splits the word into index and tag. Because the mapping is a permutation, the tag bits that the index already implies never need to be stored. The network is deliberately light. It is one pass of nibble substitutions, byte rotations, key-byte addition and XOR chains in which later bytes take in earlier results. It gives good spreading and offers no cryptographic strength.

Each word travels with its own key and direction flag. Words are accepted every cycle. The input rank captures the word, key and flag. One combinational network follows, then one output register, so every result appears two cycles after it is accepted. An optional reverse network (parameter `HAS_DECRYPT`) undoes the scrambling by applying the inverse steps in the opposite order. The block has no state machine, only a two-rank pipeline. A stage slot is either *idle* (no valid word) or *busy*, and it moves from one to the other on each clock according to `in_valid`.

Top module: `perm32_keyed`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_word` is 0.
- R2: `out_valid` equals `in_valid` from two rising edges earlier. Back-to-back valid words are all accepted, with no stall.
- R3: With `in_decrypt`=0 the result is computed as follows. Byte i is bits [8i+7:8i], and key byte j is `in_key[8j+7:8j]`. ror(v,n) is a right rotation inside a byte, and + wraps modulo 256. First, a_i = layerA(x_i). Then b_i = ror(a_i, 2+i) + key_i. Then c0=b0^ror(b1,1)^ror(b2,2)^key4, c1=b1^ror(b2,4)^ror(b3,5)^key5, c2=b2^ror(b3,7)^ror(c0,1)^key6, c3=b3^ror(c0,3)^ror(c1,4)^key7. Then d_i = layerC(c_i). Finally e0=d0^ror(d1,1)^ror(d2,5)^ror(d3,2), e1=d1^ror(d2,2)^ror(d3,6)^ror(e0,3), e2=d2^ror(d3,3)^ror(e0,7)^ror(e1,4), e3=d3^ror(e0,4)^ror(e1,1)^ror(e2,5). The output word is {e3,e2,e1,e0}.
- R4: layerA maps the high nibble through table T0 and the low nibble through T1. layerC maps the high nibble through T2 and the low nibble through T3. Listed for inputs 0 to 15: T0=38F1A65BED42709C, T1=FC27905A1BE86D34, T2=86793CAFD1E40B52, T3=0FB8C963D124A75E.
- R5: With `in_decrypt`=1, the result is the word x whose forward result under the same key equals `in_word`.
- R6: Under a fixed key, distinct input words give distinct output words.
- R7: On a cycle with `out_valid`=0, `out_word` keeps its previous value. The word and key presented while `in_valid`=0 have no effect.
- R8: The key is captured together with its word. Consecutive words in a stream may each carry a different key, and each result uses its own key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A word is presented this cycle |
| in_decrypt | input | 1 | 1 selects the reverse mapping |
| in_word | input | 32 | Word to map |
| in_key | input | 64 | Key for this word |
| out_valid | output | 1 | `out_word` holds a fresh result |
| out_word | output | 32 | Mapped word |

## Verification
Every result, and its valid flag, is due on the second rising edge after the edge that accepted the input. The bench drives each input just after a falling edge and compares the outputs at the falling edge two steps later. A two-entry queue of expected values carries each expectation forward. Idle slots are checked in the same slot: the valid flag must be low and the word must equal the last valid result. Round-trip words are checked two cycles after the reverse request, against the original word.

// File: rtl/perm_pkg.sv
package perm_pkg;

    localparam int BYTE_W = 8;
    localparam int NBYTES = 4;
    localparam int WORD_W = BYTE_W * NBYTES;
    localparam int KEY_W  = 2 * WORD_W;

    // Nibble tables, entry n held at bits [4n+3:4n].
    localparam logic [63:0] NIB_TAB0 = 64'hC907_24DE_B56A_1F83;
    localparam logic [63:0] NIB_TAB1 = 64'h43D6_8EB1_A509_72CF;
    localparam logic [63:0] NIB_TAB2 = 64'h25B0_4E1D_FAC3_9768;
    localparam logic [63:0] NIB_TAB3 = 64'hE57A_421D_369C_8BF0;

    function automatic logic [3:0] nib_fwd(input logic [1:0] sel, input logic [3:0] x);
        logic [63:0] tab;
        unique case (sel)
            2'd0: tab = NIB_TAB0;
            2'd1: tab = NIB_TAB1;
            2'd2: tab = NIB_TAB2;
            default: tab = NIB_TAB3;
        endcase
        return tab[{x, 2'b00} +: 4];
    endfunction

    function automatic logic [3:0] nib_inv(input logic [1:0] sel, input logic [3:0] y);
        logic [3:0] r;
        r = 4'd0;
        for (int i = 0; i < 16; i++) begin
            if (nib_fwd(sel, 4'(i)) == y) r = 4'(i);
        end
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] rotr8(input logic [BYTE_W-1:0] b, input int n);
        return (b >> n) | (b << (BYTE_W - n));
    endfunction

    function automatic logic [BYTE_W-1:0] rotl8(input logic [BYTE_W-1:0] b, input int n);
        return (b << n) | (b >> (BYTE_W - n));
    endfunction

endpackage

// File: rtl/perm_sbox_layer.sv
module perm_sbox_layer
    import perm_pkg::*;
#(
    parameter bit SECOND  = 1'b0,
    parameter bit INVERSE = 1'b0
) (
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);
    localparam logic [1:0] HI_SEL = SECOND ? 2'd2 : 2'd0;
    localparam logic [1:0] LO_SEL = SECOND ? 2'd3 : 2'd1;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        if (INVERSE) begin : g_inv
            assign q[BYTE_W*i+4 +: 4] = nib_inv(HI_SEL, d[BYTE_W*i+4 +: 4]);
            assign q[BYTE_W*i   +: 4] = nib_inv(LO_SEL, d[BYTE_W*i   +: 4]);
        end else begin : g_fwd
            assign q[BYTE_W*i+4 +: 4] = nib_fwd(HI_SEL, d[BYTE_W*i+4 +: 4]);
            assign q[BYTE_W*i   +: 4] = nib_fwd(LO_SEL, d[BYTE_W*i   +: 4]);
        end
    end
endmodule

// File: rtl/perm_fwd_core.sv
module perm_fwd_core
    import perm_pkg::*;
(
    input  logic [KEY_W-1:0]  key,
    input  logic [WORD_W-1:0] x,
    output logic [WORD_W-1:0] y
);
    logic [NBYTES-1:0][BYTE_W-1:0]   a, c, d, e;
    logic [NBYTES-1:0][BYTE_W-1:0]   b;
    logic [2*NBYTES-1:0][BYTE_W-1:0] kb;

    assign kb = key;

    perm_sbox_layer #(.SECOND(1'b0), .INVERSE(1'b0)) u_lay_a (.d(x), .q(a));

    always_comb begin
        for (int i = 0; i < NBYTES; i++) begin
            b[i] = rotr8(a[i], 2 + i) + kb[i];
        end
        c[0] = b[0] ^ rotr8(b[1], 1) ^ rotr8(b[2], 2) ^ kb[4];
        c[1] = b[1] ^ rotr8(b[2], 4) ^ rotr8(b[3], 5) ^ kb[5];
        c[2] = b[2] ^ rotr8(b[3], 7) ^ rotr8(c[0], 1) ^ kb[6];
        c[3] = b[3] ^ rotr8(c[0], 3) ^ rotr8(c[1], 4) ^ kb[7];
    end

    perm_sbox_layer #(.SECOND(1'b1), .INVERSE(1'b0)) u_lay_c (.d(c), .q(d));

    always_comb begin
        e[0] = d[0] ^ rotr8(d[1], 1) ^ rotr8(d[2], 5) ^ rotr8(d[3], 2);
        e[1] = d[1] ^ rotr8(d[2], 2) ^ rotr8(d[3], 6) ^ rotr8(e[0], 3);
        e[2] = d[2] ^ rotr8(d[3], 3) ^ rotr8(e[0], 7) ^ rotr8(e[1], 4);
        e[3] = d[3] ^ rotr8(e[0], 4) ^ rotr8(e[1], 1) ^ rotr8(e[2], 5);
    end

    assign y = e;
endmodule

// File: rtl/perm_inv_core.sv
module perm_inv_core
    import perm_pkg::*;
(
    input  logic [KEY_W-1:0]  key,
    input  logic [WORD_W-1:0] y,
    output logic [WORD_W-1:0] x
);
    logic [NBYTES-1:0][BYTE_W-1:0]   e, d, c, b, a;
    logic [2*NBYTES-1:0][BYTE_W-1:0] kb;

    assign kb = key;
    assign e  = y;

    // Unwind the output mixing, last byte first.
    always_comb begin
        d[3] = e[3] ^ rotr8(e[0], 4) ^ rotr8(e[1], 1) ^ rotr8(e[2], 5);
        d[2] = e[2] ^ rotr8(d[3], 3) ^ rotr8(e[0], 7) ^ rotr8(e[1], 4);
        d[1] = e[1] ^ rotr8(d[2], 2) ^ rotr8(d[3], 6) ^ rotr8(e[0], 3);
        d[0] = e[0] ^ rotr8(d[1], 1) ^ rotr8(d[2], 5) ^ rotr8(d[3], 2);
    end

    perm_sbox_layer #(.SECOND(1'b1), .INVERSE(1'b1)) u_lay_c (.d(d), .q(c));

    always_comb begin
        b[3] = c[3] ^ rotr8(c[0], 3) ^ rotr8(c[1], 4) ^ kb[7];
        b[2] = c[2] ^ rotr8(b[3], 7) ^ rotr8(c[0], 1) ^ kb[6];
        b[1] = c[1] ^ rotr8(b[2], 4) ^ rotr8(b[3], 5) ^ kb[5];
        b[0] = c[0] ^ rotr8(b[1], 1) ^ rotr8(b[2], 2) ^ kb[4];
        for (int i = 0; i < NBYTES; i++) begin
            a[i] = rotl8(b[i] - kb[i], 2 + i);
        end
    end

    perm_sbox_layer #(.SECOND(1'b0), .INVERSE(1'b1)) u_lay_a (.d(a), .q(x));
endmodule

// File: rtl/perm32_keyed.sv
module perm32_keyed
    import perm_pkg::*;
#(
    parameter bit HAS_DECRYPT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_decrypt,
    input  logic [WORD_W-1:0] in_word,
    input  logic [KEY_W-1:0]  in_key,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);
    logic              s1_valid;
    logic              s1_dec;
    logic [WORD_W-1:0] s1_word;
    logic [KEY_W-1:0]  s1_key;
    logic [WORD_W-1:0] fwd_word;
    logic [WORD_W-1:0] inv_word;
    logic [WORD_W-1:0] result;

    // Input rank: word, key and direction are captured together.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_dec   <= 1'b0;
            s1_word  <= '0;
            s1_key   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_dec  <= in_decrypt;
                s1_word <= in_word;
                s1_key  <= in_key;
            end
        end
    end

    perm_fwd_core u_fwd (.key(s1_key), .x(s1_word), .y(fwd_word));

    if (HAS_DECRYPT) begin : g_dec
        perm_inv_core u_inv (.key(s1_key), .y(s1_word), .x(inv_word));
    end else begin : g_no_dec
        assign inv_word = fwd_word;
    end

    assign result = s1_dec ? inv_word : fwd_word;

    // Output rank: updated only by a valid word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_word <= result;
        end
    end
endmodule

// File: rtl/perm32_keyed_chk.sv
module perm32_keyed_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        out_valid,
    input logic [31:0] out_word
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_R1: assert (out_valid == 1'b0 && out_word == 32'd0);
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && !out_valid) |-> $stable(out_word));

    assert_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_word));
endmodule

bind perm32_keyed perm32_keyed_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .out_valid(out_valid), .out_word(out_word)
);

// File: tb/sim_perm32_keyed.sv
module sim_perm32_keyed;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_decrypt;
    logic [31:0] in_word;
    logic [63:0] in_key;
    logic        out_valid;
    logic [31:0] out_word;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    perm32_keyed u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_decrypt(in_decrypt),
        .in_word(in_word), .in_key(in_key), .out_valid(out_valid), .out_word(out_word)
    );

    // Tables from R4, entry for input n taken from the most significant end.
    function automatic logic [3:0] tnib(input int t, input logic [3:0] v);
        logic [63:0] s;
        case (t)
            0: s = 64'h38F1A65BED42709C;
            1: s = 64'hFC27905A1BE86D34;
            2: s = 64'h86793CAFD1E40B52;
            default: s = 64'h0FB8C963D124A75E;
        endcase
        return s[60 - 4*int'(v) +: 4];
    endfunction

    function automatic logic [7:0] rr(input logic [7:0] v, input int n);
        return (v >> n) | (v << (8 - n));
    endfunction

    function automatic logic [31:0] ref_enc(input logic [31:0] x, input logic [63:0] k);
        logic [7:0] a[4], b[4], c[4], d[4], e[4], kk[8];
        for (int j = 0; j < 8; j++) kk[j] = k[8*j +: 8];
        for (int i = 0; i < 4; i++) begin
            a[i] = {tnib(0, x[8*i+4 +: 4]), tnib(1, x[8*i +: 4])};
            b[i] = rr(a[i], 2 + i) + kk[i];
        end
        c[0] = b[0] ^ rr(b[1], 1) ^ rr(b[2], 2) ^ kk[4];
        c[1] = b[1] ^ rr(b[2], 4) ^ rr(b[3], 5) ^ kk[5];
        c[2] = b[2] ^ rr(b[3], 7) ^ rr(c[0], 1) ^ kk[6];
        c[3] = b[3] ^ rr(c[0], 3) ^ rr(c[1], 4) ^ kk[7];
        for (int i = 0; i < 4; i++) d[i] = {tnib(2, c[i][7:4]), tnib(3, c[i][3:0])};
        e[0] = d[0] ^ rr(d[1], 1) ^ rr(d[2], 5) ^ rr(d[3], 2);
        e[1] = d[1] ^ rr(d[2], 2) ^ rr(d[3], 6) ^ rr(e[0], 3);
        e[2] = d[2] ^ rr(d[3], 3) ^ rr(e[0], 7) ^ rr(e[1], 4);
        e[3] = d[3] ^ rr(e[0], 4) ^ rr(e[1], 1) ^ rr(e[2], 5);
        return {e[3], e[2], e[1], e[0]};
    endfunction

    // Two-slot expectation queue: slot 1 is due at the current sample point.
    bit          pv[2];
    logic [31:0] pw[2];
    string       preq[2];
    int          ptag[2];
    logic [31:0] model_out = 32'd0;
    logic [31:0] got[256];

    task automatic check_slot();
        if (pv[1]) model_out = pw[1];
        tests++;
        if (out_valid !== pv[1]) begin
            fails++;
            $display("FAIL R2 out_valid: got %b exp %b", out_valid, pv[1]);
        end
        tests++;
        if (out_word !== model_out) begin
            fails++;
            $display("FAIL %s out_word: got %h exp %h", pv[1] ? preq[1] : "R7", out_word, model_out);
        end
        if (pv[1] && ptag[1] >= 0) got[ptag[1]] = out_word;
    endtask

    task automatic step(input bit v, input bit dec, input logic [31:0] w,
                        input logic [63:0] k, input logic [31:0] ew,
                        input string req, input int tag);
        @(negedge clk);
        check_slot();
        pv[1] = pv[0]; pw[1] = pw[0]; preq[1] = preq[0]; ptag[1] = ptag[0];
        pv[0] = v; pw[0] = ew; preq[0] = req; ptag[0] = tag;
        in_valid = v; in_decrypt = dec; in_word = w; in_key = k;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            step(1'b0, $urandom() % 2 == 0, $urandom(), {$urandom(), $urandom()}, 32'd0, "R7", -1);
    endtask

    task automatic enc(input logic [31:0] x, input logic [63:0] k, input string req, input int tag);
        step(1'b1, 1'b0, x, k, ref_enc(x, k), req, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        logic [63:0] fk;
        int dup;
        void'($urandom(32'd20240611));
        for (int s = 0; s < 2; s++) begin
            pv[s] = 1'b0; pw[s] = 32'd0; preq[s] = "R7"; ptag[s] = -1;
        end
        rst_n = 1'b0; in_valid = 1'b0; in_decrypt = 1'b0; in_word = '1; in_key = '1;
        repeat (3) @(negedge clk);
        tests++;
        if (out_valid !== 1'b0 || out_word !== 32'd0) begin
            fails++;
            $display("FAIL R1 reset: got %b/%h exp 0/00000000", out_valid, out_word);
        end
        rst_n = 1'b1;
        in_word = '0; in_key = '0;

        // Directed corners (R4 tables, R3 network), each followed by idle slots (R7).
        enc(32'h0000_0000, 64'h0, "R4", -1);
        idle(3);
        enc(32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R3", -1);
        enc(32'h0A00_0001, 64'h0123_4567_89AB_CDEF, "R3", -1);
        enc(32'h8000_0000, 64'h8000_0000_0000_0001, "R3", -1);
        idle(4);

        // Back-to-back stream, a fresh key on every word (R8, R2).
        for (int i = 0; i < 300; i++) begin
            if ($urandom() % 4 == 0) idle(1);
            else enc($urandom(), {$urandom(), $urandom()}, "R8", -1);
        end
        idle(2);

        // Reverse direction: feed the forward image, expect the original (R5).
        for (int i = 0; i < 150; i++) begin
            logic [31:0] x;
            logic [63:0] k;
            x = $urandom(); k = {$urandom(), $urandom()};
            if (i % 3 == 0) enc(x, k, "R3", -1);
            step(1'b1, 1'b1, ref_enc(x, k), k, x, "R5", -1);
            if (i % 5 == 0) idle(1);
        end
        step(1'b1, 1'b1, ref_enc(32'h0, 64'h0), 64'h0, 32'h0, "R5", -1);
        step(1'b1, 1'b1, ref_enc(32'hFFFF_FFFF, '1), '1, 32'hFFFF_FFFF, "R5", -1);
        idle(2);

        // Distinct inputs under one key must give distinct outputs (R6).
        fk = {$urandom(), $urandom()};
        for (int i = 0; i < 256; i++)
            enc((32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F, fk, "R6", i);
        idle(2);
        dup = 0;
        for (int i = 0; i < 256; i++)
            for (int j = i + 1; j < 256; j++)
                if (got[i] == got[j]) dup++;
        tests++;
        if (dup != 0) begin
            fails++;
            $display("FAIL R6 collisions: got %0d exp 0", dup);
        end

        finish_run();
    end
endmodule